// File: doc/BRIEF.md
# Interlaced Raster Sync Generator

This block produces the timing skeleton of an interlaced raster scan from a single pixel clock. Every frame consists of two fields: the first field carries the odd picture lines and the second carries the even ones. Each field is a whole number of lines plus one half line, so a frame always holds an odd number of lines. Both fields use the same vertical layout. The vertical sync pulse comes first, then the back porch, then the active lines and then the front porch.

Each field begins with its vertical sync pulse. The first field starts its pulse on a line boundary (pixel 0). The second field starts its pulse half a line later, at the line midpoint. A receiver uses this offset to tell the two fields apart. The pixel counter never pauses, so horizontal sync keeps running through vertical retrace. The block outputs the two active-low syncs, a blanking flag, a field flag, and the pixel and field-relative line coordinates. A video source uses these to fetch and time its pixel data.

Top module: `ilsync_gen`

## Requirements
- R1: While the synchronous active-low reset is held, and on the first cycle after it is released, the outputs are: pixel 0, line 0, field flag 0 (first/odd field), hsync_n high, vsync_n low (the first field's vertical sync starts at once) and blank high.
- R2: The pixel coordinate counts up by one each clock. It wraps from H_TOTAL-1 to 0, where H_TOTAL = H_ACTIVE+H_FRONT+H_SYNC+H_BACK. It never stops or resets at field boundaries.
- R3: Every line has the same horizontal layout: active pixels, then front porch, then sync, then back porch. hsync_n is low exactly for pixels H_ACTIVE+H_FRONT up to H_ACTIVE+H_FRONT+H_SYNC-1 on every line, including every line of vertical retrace. Each vertical sync pulse therefore contains exactly V_SYNC hsync pulses.
- R4: The line coordinate advances when the pixel counter wraps. With FL = V_SYNC+V_BACK+V_ACTIVE+V_FRONT, the first field runs lines 0..FL, and its line FL ends at pixel H_TOTAL/2-1. The second field's line 0 starts at pixel H_TOTAL/2, and the field ends after a full line FL.
- R5: The field flag is 0 in the first field and 1 in the second. It toggles at each field boundary, in the same cycle that the line counter returns to 0.
- R6: In the first field, vsync_n falls at pixel 0 of line 0 and stays low for exactly V_SYNC*H_TOTAL clocks.
- R7: In the second field, vsync_n falls at pixel H_TOTAL/2 of line 0 and stays low for exactly V_SYNC*H_TOTAL clocks.
- R8: blank is low only when the pixel is below H_ACTIVE and the line lies in V_SYNC+V_BACK up to V_SYNC+V_BACK+V_ACTIVE-1. blank is high for the whole vertical retrace.
- R9: One frame (two fields) lasts (2*FL+1)*H_TOTAL clocks, measured between successive falls of the field flag.
- R10: Asserting reset in the middle of a frame returns the generator to the R1 state. The scan then resumes from pixel 0 of line 0 in the first field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High when no picture data may be shown |
| field_o | output | 1 | 0 in the first (odd-line) field, 1 in the second |
| pixel_o | output | HW | Pixel position within the line |
| line_o | output | VW | Line position within the current field |

## Verification
At the end of the second field, three events fall in the same clock: the pixel counter wraps, the line counter returns to 0 and the field flag clears. In the second field, the vertical sync edge coincides with the pixel midpoint of the line rather than with a wrap. Both cases are provoked by running the scan freely across several frames with a small raster. Every output is compared each cycle against a model derived only from the elapsed clock count. The sync edges are also measured separately for their starting pixel, their pulse length and the number of hsync pulses they contain.

// File: rtl/ilsync_pkg.sv
// Shared types for the interlaced sync generator.
// Assumes nothing beyond a single pixel clock domain.
package ilsync_pkg;
    typedef enum logic {
        FIELD_ODD  = 1'b0,
        FIELD_EVEN = 1'b1
    } field_e;
endpackage

// File: rtl/ilsync_hcount.sv
// Free-running pixel counter for one line.
// Assumes H_TOTAL >= 2; it never pauses, so horizontal timing is continuous.
module ilsync_hcount #(
    parameter int H_TOTAL = 800,
    parameter int HW      = $clog2(H_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] pix,
    output logic          pix_last
);
    localparam logic [HW-1:0] LAST = HW'(H_TOTAL - 1);

    // Flags the final pixel of a line.
    always_comb pix_last = (pix == LAST);

    // Counts pixels and wraps at the end of each line.
    always_ff @(posedge clk) begin
        if (!rst_n)        pix <= '0;
        else if (pix_last) pix <= '0;
        else               pix <= pix + 1'b1;
    end

    AST_PIX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix == LAST) |=> (pix == '0)); // R2
    AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix != LAST) |=> (pix == $past(pix) + 1'b1)); // R2
endmodule

// File: rtl/ilsync_vseq.sv
// Field-relative line counter and field parity.
// The first field ends at the midpoint of its last line; the second
// field starts there and ends at a full line wrap. Assumes H_TOTAL even.
module ilsync_vseq
    import ilsync_pkg::*;
#(
    parameter int H_TOTAL = 800,
    parameter int FL      = 262,
    parameter int HW      = $clog2(H_TOTAL),
    parameter int VW      = $clog2(FL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] pix,
    input  logic          pix_last,
    output logic [VW-1:0] line,
    output field_e        field
);
    localparam logic [HW-1:0] MID_LAST = HW'(H_TOTAL / 2 - 1);
    localparam logic [HW-1:0] MID      = HW'(H_TOTAL / 2);
    localparam logic [VW-1:0] LINE_END = VW'(FL);

    logic odd_done;
    logic even_done;

    // Detects the two field boundaries: mid-line in odd, line end in even.
    always_comb begin
        odd_done  = (field == FIELD_ODD)  && (line == LINE_END) && (pix == MID_LAST);
        even_done = (field == FIELD_EVEN) && (line == LINE_END) && pix_last;
    end

    // Advances the line count and flips parity at each field boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line  <= '0;
            field <= FIELD_ODD;
        end else if (odd_done) begin
            line  <= '0;
            field <= FIELD_EVEN;
        end else if (even_done) begin
            line  <= '0;
            field <= FIELD_ODD;
        end else if (pix_last) begin
            line  <= line + 1'b1;
        end
    end

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (line <= LINE_END)); // R4
    AST_FIELD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (field != $past(field)) |->
            ((line == '0) && (((field == FIELD_EVEN) && (pix == MID)) ||
                              ((field == FIELD_ODD)  && (pix == '0))))); // R5
endmodule

// File: rtl/ilsync_decode.sv
// Decodes syncs and blanking from the pixel, line and field state.
// Assumes V_BACK >= 1 so the half line of a delayed vsync never meets
// an active line; all outputs follow the counters in the same cycle.
module ilsync_decode
    import ilsync_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_FRONT  = 16,
    parameter int H_SYNC   = 96,
    parameter int H_TOTAL  = 800,
    parameter int V_SYNC   = 3,
    parameter int V_BACK   = 15,
    parameter int V_ACTIVE = 240,
    parameter int FL       = 262,
    parameter int HW       = $clog2(H_TOTAL),
    parameter int VW       = $clog2(FL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] pix,
    input  logic [VW-1:0] line,
    input  field_e        field,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          blank
);
    localparam logic [HW-1:0] HS_BEG  = HW'(H_ACTIVE + H_FRONT);
    localparam logic [HW-1:0] HS_END  = HW'(H_ACTIVE + H_FRONT + H_SYNC);
    localparam logic [HW-1:0] HA_END  = HW'(H_ACTIVE);
    localparam logic [HW-1:0] MID     = HW'(H_TOTAL / 2);
    localparam logic [VW-1:0] VS_END  = VW'(V_SYNC);
    localparam logic [VW-1:0] VA_BEG  = VW'(V_SYNC + V_BACK);
    localparam logic [VW-1:0] VA_END  = VW'(V_SYNC + V_BACK + V_ACTIVE);

    logic in_vsync;
    logic in_view;

    // Horizontal sync window, identical on every line.
    always_comb hsync_n = !((pix >= HS_BEG) && (pix < HS_END));

    // Vertical sync: whole lines, plus a trailing half line in the even field.
    always_comb begin
        in_vsync = (line < VS_END) ||
                   ((field == FIELD_EVEN) && (line == VS_END) && (pix < MID));
        vsync_n  = !in_vsync;
    end

    // Picture area: active pixels on active lines only.
    always_comb begin
        in_view = (pix < HA_END) && (line >= VA_BEG) && (line < VA_END);
        blank   = !in_view;
    end

    AST_VSYNC_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> blank); // R8
    AST_VSYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> ((line == '0) &&
            (((field == FIELD_ODD) && (pix == '0)) ||
             ((field == FIELD_EVEN) && (pix == MID))))); // R7
endmodule

// File: rtl/ilsync_gen.sv
// Top of the interlaced raster sync generator.
// Assumes an even H_TOTAL and V_BACK >= 1; each field is FL lines and a
// half, so a frame is 2*FL+1 lines.
module ilsync_gen
    import ilsync_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_FRONT  = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BACK   = 48,
    parameter int V_ACTIVE = 240,
    parameter int V_FRONT  = 4,
    parameter int V_SYNC   = 3,
    parameter int V_BACK   = 15,
    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
    localparam int FL      = V_SYNC + V_BACK + V_ACTIVE + V_FRONT,
    localparam int HW      = $clog2(H_TOTAL),
    localparam int VW      = $clog2(FL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          blank,
    output logic          field_o,
    output logic [HW-1:0] pixel_o,
    output logic [VW-1:0] line_o
);
    logic [HW-1:0] pix;
    logic          pix_last;
    logic [VW-1:0] line;
    field_e        field;

    ilsync_hcount #(.H_TOTAL(H_TOTAL), .HW(HW)) u_hcount (
        .clk(clk), .rst_n(rst_n), .pix(pix), .pix_last(pix_last)
    );

    ilsync_vseq #(.H_TOTAL(H_TOTAL), .FL(FL), .HW(HW), .VW(VW)) u_vseq (
        .clk(clk), .rst_n(rst_n), .pix(pix), .pix_last(pix_last),
        .line(line), .field(field)
    );

    ilsync_decode #(
        .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC),
        .H_TOTAL(H_TOTAL), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
        .V_ACTIVE(V_ACTIVE), .FL(FL), .HW(HW), .VW(VW)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .pix(pix), .line(line), .field(field),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank)
    );

    // Presents the coordinates and parity at the ports.
    always_comb begin
        pixel_o = pix;
        line_o  = line;
        field_o = field;
    end
endmodule

// File: tb/tb_ilsync_gen.sv
module tb_ilsync_gen;
    localparam int HA = 16, HF = 2, HS = 4, HB = 2;
    localparam int VA = 4,  VF = 1, VS = 2, VB = 1;
    localparam int HT = HA + HF + HS + HB;   // 24
    localparam int HALF = HT / 2;            // 12
    localparam int FLN = VS + VB + VA + VF;  // 8
    localparam int FRAME = (2 * FLN + 1) * HT;
    localparam int HWB = $clog2(HT);
    localparam int VWB = $clog2(FLN + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync_n, vsync_n, blank, field_o;
    logic [HWB-1:0] pixel_o;
    logic [VWB-1:0] line_o;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    ilsync_gen #(
        .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .blank(blank), .field_o(field_o), .pixel_o(pixel_o), .line_o(line_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Model: expected outputs after t clocks since reset release.
    task automatic model(input int t, output int h, output int v, output int f,
                         output int hs, output int vs, output int bl);
        int p, q;
        p = t % FRAME;
        h = t % HT;
        if (p < FLN * HT + HALF) begin
            f = 0; v = p / HT;
            vs = (p < VS * HT) ? 0 : 1;
        end else begin
            q = p - (FLN * HT + HALF);
            f = 1; v = (q + HALF) / HT;
            vs = (q < VS * HT) ? 0 : 1;
        end
        hs = (h >= HA + HF && h < HA + HF + HS) ? 0 : 1;
        bl = (h < HA && v >= VS + VB && v < VS + VB + VA) ? 0 : 1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic release_reset();
        rst_n = 1'b1;   // at a negedge; outputs show t=0 until the next posedge
    endtask

    task automatic t_reset_state(input string tag);
        chk({tag, " pixel"}, pixel_o, 0);
        chk({tag, " line"}, line_o, 0);
        chk({tag, " field"}, field_o, 0);
        chk({tag, " hsync_n"}, hsync_n, 1);
        chk({tag, " vsync_n"}, vsync_n, 0);
        chk({tag, " blank"}, blank, 1);
    endtask

    // Compares every output against the model for n cycles from t0.
    task automatic t_scan(input int t0, input int n);
        int h, v, f, hs, vs, bl;
        for (int t = t0; t < t0 + n; t++) begin
            model(t, h, v, f, hs, vs, bl);
            chk("R2 pixel", pixel_o, h);
            chk("R4 line", line_o, v);
            chk("R5 field", field_o, f);
            chk("R3 hsync_n", hsync_n, hs);
            chk(f ? "R7 vsync_n" : "R6 vsync_n", vsync_n, vs);
            chk("R8 blank", blank, bl);
            @(posedge clk); @(negedge clk);
        end
    endtask

    // Measures each vsync pulse: start pixel, length, hsync pulses inside.
    task automatic t_vsync_shape(input int frames);
        int len = 0, hcnt = 0, startpix = 0, startfld = 0, seen = 0;
        logic pv = 1'b0, ph = 1'b1;
        for (int c = 0; c < frames * FRAME + 2 * HT; c++) begin
            if (!vsync_n && pv) begin
                startpix = pixel_o; startfld = field_o; len = 0; hcnt = 0;
            end
            if (!vsync_n) begin
                len++;
                if (!hsync_n && ph) hcnt++;
            end
            if (vsync_n && !pv && c > 0) begin
                seen++;
                if (startfld == 0) begin
                    chk("R6 vsync start pixel", startpix, 0);
                    chk("R6 vsync length", len, VS * HT);
                end else begin
                    chk("R7 vsync start pixel", startpix, HALF);
                    chk("R7 vsync length", len, VS * HT);
                end
                chk("R3 hsync pulses in vsync", hcnt, VS);
            end
            pv = vsync_n; ph = hsync_n;
            @(posedge clk); @(negedge clk);
        end
        chk("R6 R7 vsync pulses seen", seen >= 2 * frames ? 1 : 0, 1);
    endtask

    // Measures the spacing of field-flag falls.
    task automatic t_frame_len();
        int cnt = 0, marks = 0, last = 0;
        logic pf = field_o;
        for (int c = 0; c < 3 * FRAME; c++) begin
            @(posedge clk); @(negedge clk);
            cnt++;
            if (pf && !field_o) begin
                if (marks > 0) chk("R9 frame length", cnt - last, FRAME);
                last = cnt; marks++;
            end
            pf = field_o;
        end
        chk("R9 frame marks", marks >= 2 ? 1 : 0, 1);
    endtask

    task automatic t_midreset();
        repeat (FRAME / 2 + 7) @(posedge clk);
        do_reset();
        t_reset_state("R10 reset mid-frame");
        release_reset();
        t_scan(0, HT * 4);
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state("R1 held");
        release_reset();
        t_reset_state("R1 released");
        t_scan(0, 2 * FRAME + HT);
        do_reset(); release_reset();
        t_vsync_shape(2);
        do_reset(); release_reset();
        t_frame_len();
        t_midreset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule